// File: doc/BRIEF.md
# Anticollision Tag Command Controller

This block is the command-level controller of a contactless tag that takes part in slot-based anticollision. A front end (outside this block) demodulates a request frame, checks its CRC and presents the first two payload bytes together with a one-cycle strobe. The controller holds the tag's lifecycle state and its 8-bit chip ID. It decides whether the command is legal in the current state, updates the state and the ID, and requests a reply from the transmit path. The reply is either the chip ID, a block-read indication or a unique-identifier indication.

The chip ID comes from a random source. The ID is drawn when the field appears and again on each Initiate. Pcall16 redraws only the low nibble of the ID, and that low nibble is the tag's time slot. A reader collects replies slot by slot, picks one tag with Select, works with it, and then either releases it for good with Completion or puts it back into the anticollision pool. A loss of the carrier field is the only way out of the deactivated state.

Top module: `tag_anticol_fsm`

## Requirements
- R1: While rst_n is low at a clock edge, the state becomes Power-off, the chip ID becomes 00h, and rsp_vld and cmd_acc become 0. State codes on state_o are: Power-off 0, Ready 1, Inventory 2, Selected 3, Deselected 4, Deactivated 5.
- R2: A clock edge with field_on low puts the tag in Power-off from any state. A frame presented in that cycle is ignored: no reply and no acceptance.
- R3: A clock edge in Power-off with field_on high moves the tag to Ready and loads the chip ID from rnd. A frame in that cycle is ignored.
- R4: Initiate (byte0 06h, byte1 00h) in Ready or Inventory moves the tag to Inventory, loads the chip ID from rnd, and replies with the new ID (rsp_kind 1).
- R5: Pcall16 (byte0 06h, byte1 04h) in Inventory replaces the ID's low nibble with rnd[3:0] and keeps the high nibble. The tag replies with the ID (rsp_kind 1) only when the new low nibble is 0. The command is accepted either way.
- R6: Slot_marker (byte0 low nibble 6h, high nibble N from 1 to 15) in Inventory leaves the ID unchanged and replies with the ID only when the ID's low nibble equals N. The command is accepted either way.
- R7: Select (byte0 0Eh) whose byte1 equals the chip ID moves a tag in Inventory, Selected or Deselected to Selected and replies with the ID. In Inventory and Deselected, a Select with any other byte1 is ignored.
- R8: A Selected tag that receives a Select with a byte1 different from its ID moves to Deselected. It accepts the command but does not reply.
- R9: Read_block (08h) replies with rsp_kind 2, Get_UID (0Bh) replies with rsp_kind 3, and Write_block (09h) is accepted without a reply. All three act only in Selected. In every other state they are ignored.
- R10: Reset_to_inventory (0Ch) in Selected moves the tag to Inventory without a reply and keeps the ID.
- R11: Completion (0Fh) in Selected moves the tag to Deactivated without a reply. In Deactivated, every frame is ignored for as long as the field stays present.
- R12: Any command that R4 to R11 do not list for the current state, and any unknown code (including byte0 06h with a byte1 other than 00h or 04h), leaves the state and the ID unchanged and gives no reply and no acceptance.
- R13: rsp_vld and cmd_acc are registered. They are high for exactly the one cycle after the edge that sampled the strobe. rsp_id always shows the chip ID as updated by that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| field_on | input | 1 | Carrier field present |
| frame_vld | input | 1 | One-cycle strobe: a CRC-clean request frame is presented |
| cmd_b0 | input | 8 | First payload byte (command code) |
| cmd_b1 | input | 8 | Second payload byte (sub-code, chip ID or address) |
| rnd | input | 8 | Random source for chip ID draws |
| rsp_vld | output | 1 | Reply request pulse |
| rsp_kind | output | 2 | Reply kind: 0 none, 1 chip ID, 2 block read, 3 UID |
| rsp_id | output | 8 | Current chip ID |
| cmd_acc | output | 1 | Command accepted pulse |
| state_o | output | 3 | Current state code |

## Verification
Every result is due exactly one clock after the edge that samples its cause. This holds for frame replies, acceptance, the state change and the ID update, and also for the field-driven moves into Ready or Power-off. The bench changes inputs on the falling edge, lets one rising edge pass, and compares on the next falling edge. It then waits one more cycle and confirms that both pulses have dropped. A sweep covers every first-byte value in Ready, Inventory, Selected, Deselected and Deactivated. Each first byte is paired with four second-byte choices: the Initiate and Pcall16 sub-codes, the matching ID and a mismatching ID. Directed runs then walk all sixteen Pcall16 nibbles and all fifteen slot numbers.

// File: rtl/tag_anticol_pkg.sv
// Shared types for the anticollision tag controller.
// Assumes 8-bit command bytes and a 4-bit slot field in the chip ID.
package tag_anticol_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_READY  = 3'd1,
        ST_INVENT = 3'd2,
        ST_SEL    = 3'd3,
        ST_DESEL  = 3'd4,
        ST_DEACT  = 3'd5
    } tag_state_e;

    typedef enum logic [3:0] {
        C_NONE, C_INIT, C_PCALL, C_SLOT, C_READ,
        C_WRITE, C_UID, C_RSTINV, C_SELECT, C_COMPL
    } tag_cmd_e;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_ID   = 2'd1,
        RK_READ = 2'd2,
        RK_UID  = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ID_HOLD, ID_FULL, ID_SLOT
    } id_op_e;

    localparam logic [3:0] OPC_SLOTFAM = 4'h6;
    localparam logic [7:0] SUB_INIT    = 8'h00;
    localparam logic [7:0] SUB_PCALL   = 8'h04;
    localparam logic [7:0] OPC_READ    = 8'h08;
    localparam logic [7:0] OPC_WRITE   = 8'h09;
    localparam logic [7:0] OPC_UID     = 8'h0B;
    localparam logic [7:0] OPC_RSTINV  = 8'h0C;
    localparam logic [7:0] OPC_SELECT  = 8'h0E;
    localparam logic [7:0] OPC_COMPL   = 8'h0F;

endpackage

// File: rtl/tag_cmd_decode.sv
// Classifies the first two payload bytes into a command.
// Purely combinational; assumes the bytes are stable while frame_vld is high.
module tag_cmd_decode
    import tag_anticol_pkg::*;
#(
    parameter int SLOT_W = 4
) (
    input  logic [7:0]        b0,
    input  logic [7:0]        b1,
    output tag_cmd_e          cmd,
    output logic [SLOT_W-1:0] slot_n
);

    // Command classification from the opcode byte and, for the 6h family, the sub-code.
    always_comb begin
        cmd    = C_NONE;
        slot_n = b0[7 -: SLOT_W];
        if (b0[3:0] == OPC_SLOTFAM) begin
            if (b0[7:4] != 4'h0)      cmd = C_SLOT;
            else if (b1 == SUB_INIT)  cmd = C_INIT;
            else if (b1 == SUB_PCALL) cmd = C_PCALL;
        end else begin
            case (b0)
                OPC_READ:   cmd = C_READ;
                OPC_WRITE:  cmd = C_WRITE;
                OPC_UID:    cmd = C_UID;
                OPC_RSTINV: cmd = C_RSTINV;
                OPC_SELECT: cmd = C_SELECT;
                OPC_COMPL:  cmd = C_COMPL;
                default:    cmd = C_NONE;
            endcase
        end
    end

endmodule

// File: rtl/tag_id_reg.sv
// Holds the chip ID. It is loaded whole from the random source, or only in its
// slot field (low bits). Assumes op is ID_HOLD unless the controller asks for a load.
module tag_id_reg
    import tag_anticol_pkg::*;
#(
    parameter int ID_W   = 8,
    parameter int SLOT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  id_op_e          op,
    input  logic [ID_W-1:0] rnd,
    output logic [ID_W-1:0] id
);

    // ID storage with full or slot-only reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id <= '0;
        end else begin
            case (op)
                ID_FULL: id <= rnd;
                ID_SLOT: id[SLOT_W-1:0] <= rnd[SLOT_W-1:0];
                default: id <= id;
            endcase
        end
    end

    p_slot_keeps_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ID_SLOT) |=> (id[ID_W-1:SLOT_W] == $past(id[ID_W-1:SLOT_W])))
        else $error("slot reload changed the upper ID bits");

    p_slot_takes_rnd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ID_SLOT) |=> (id[SLOT_W-1:0] == $past(rnd[SLOT_W-1:0])))
        else $error("slot reload did not take the random nibble");

endmodule

// File: rtl/tag_anticol_fsm.sv
// Tag-side anticollision and selection controller (top).
// Tracks the lifecycle state, decides command acceptance and registers the
// reply request. Assumes frame_vld marks CRC-clean frames and lasts one cycle.
module tag_anticol_fsm
    import tag_anticol_pkg::*;
#(
    parameter int ID_W   = 8,
    parameter int SLOT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            field_on,
    input  logic            frame_vld,
    input  logic [7:0]      cmd_b0,
    input  logic [7:0]      cmd_b1,
    input  logic [ID_W-1:0] rnd,
    output logic            rsp_vld,
    output logic [1:0]      rsp_kind,
    output logic [ID_W-1:0] rsp_id,
    output logic            cmd_acc,
    output logic [2:0]      state_o
);

    localparam int NSLOT = 1 << SLOT_W;

    tag_state_e            state, nxt;
    tag_cmd_e              cmd;
    logic [SLOT_W-1:0]     slot_n;
    id_op_e                id_op;
    logic [ID_W-1:0]       id;
    logic                  rv, acc, sel_hit, slot_hit;
    rsp_kind_e             rk;

    tag_cmd_decode #(.SLOT_W(SLOT_W)) u_dec (
        .b0     (cmd_b0),
        .b1     (cmd_b1),
        .cmd    (cmd),
        .slot_n (slot_n)
    );

    tag_id_reg #(.ID_W(ID_W), .SLOT_W(SLOT_W)) u_id (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (id_op),
        .rnd   (rnd),
        .id    (id)
    );

    assign sel_hit  = (cmd_b1[ID_W-1:0] == id);
    assign slot_hit = (32'(id[SLOT_W-1:0]) == 32'(slot_n)) && (32'(slot_n) < NSLOT);

    // Next-state, ID action and reply decision for the sampled frame.
    always_comb begin
        nxt   = state;
        id_op = ID_HOLD;
        rv    = 1'b0;
        acc   = 1'b0;
        rk    = RK_NONE;
        if (!field_on) begin
            nxt = ST_OFF;
        end else if (state == ST_OFF) begin
            nxt   = ST_READY;
            id_op = ID_FULL;
        end else if (frame_vld) begin
            case (state)
                ST_READY, ST_INVENT: begin
                    if (cmd == C_INIT) begin
                        nxt = ST_INVENT; id_op = ID_FULL;
                        acc = 1'b1; rv = 1'b1; rk = RK_ID;
                    end else if (state == ST_INVENT) begin
                        if (cmd == C_PCALL) begin
                            id_op = ID_SLOT; acc = 1'b1;
                            rv = (rnd[SLOT_W-1:0] == '0);
                            rk = rv ? RK_ID : RK_NONE;
                        end else if (cmd == C_SLOT) begin
                            acc = 1'b1; rv = slot_hit;
                            rk  = rv ? RK_ID : RK_NONE;
                        end else if (cmd == C_SELECT && sel_hit) begin
                            nxt = ST_SEL; acc = 1'b1; rv = 1'b1; rk = RK_ID;
                        end
                    end
                end
                ST_SEL: begin
                    case (cmd)
                        C_READ:   begin acc = 1'b1; rv = 1'b1; rk = RK_READ; end
                        C_WRITE:  acc = 1'b1;
                        C_UID:    begin acc = 1'b1; rv = 1'b1; rk = RK_UID; end
                        C_RSTINV: begin acc = 1'b1; nxt = ST_INVENT; end
                        C_COMPL:  begin acc = 1'b1; nxt = ST_DEACT; end
                        C_SELECT: begin
                            acc = 1'b1;
                            if (sel_hit) begin rv = 1'b1; rk = RK_ID; end
                            else nxt = ST_DESEL;
                        end
                        default: ;
                    endcase
                end
                ST_DESEL: begin
                    if (cmd == C_SELECT && sel_hit) begin
                        nxt = ST_SEL; acc = 1'b1; rv = 1'b1; rk = RK_ID;
                    end
                end
                default: ;
            endcase
        end
    end

    // State and registered reply request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            rsp_vld  <= 1'b0;
            rsp_kind <= RK_NONE;
            cmd_acc  <= 1'b0;
        end else begin
            state    <= nxt;
            rsp_vld  <= rv;
            rsp_kind <= rk;
            cmd_acc  <= acc;
        end
    end

    assign rsp_id  = id;
    assign state_o = state;

    p_field_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !field_on |=> (state == ST_OFF && !rsp_vld && !cmd_acc))
        else $error("field loss did not force power-off");

    p_ready_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && field_on) |=> (state == ST_READY && id == $past(rnd)))
        else $error("power-up did not enter ready with a fresh ID");

    p_deact_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEACT && field_on) |=> (state == ST_DEACT && !rsp_vld && !cmd_acc))
        else $error("deactivated tag reacted to a frame");

    p_mem_only_selected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && (rsp_kind == RK_READ || rsp_kind == RK_UID)) |-> ($past(state) == ST_SEL))
        else $error("memory reply outside selected state");

    p_reply_needs_frame_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld || cmd_acc) |-> $past(frame_vld && field_on))
        else $error("reply or acceptance without a frame");

    p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd5)
        else $error("illegal state code");

endmodule

// File: tb/tb_tag_anticol_fsm.sv
module tb_tag_anticol_fsm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       field_on = 1'b0;
    logic       frame_vld = 1'b0;
    logic [7:0] cmd_b0 = '0, cmd_b1 = '0, rnd = '0;
    logic       rsp_vld, cmd_acc;
    logic [1:0] rsp_kind;
    logic [7:0] rsp_id;
    logic [2:0] state_o;

    int vectors = 0;
    int fails = 0;
    int exp_st = 0;
    logic [7:0] exp_id = '0;
    logic [15:0] lfsr = 16'hACE1;
    bit done = 0;

    always #5 clk = ~clk;

    tag_anticol_fsm dut (
        .clk(clk), .rst_n(rst_n), .field_on(field_on), .frame_vld(frame_vld),
        .cmd_b0(cmd_b0), .cmd_b1(cmd_b1), .rnd(rnd), .rsp_vld(rsp_vld),
        .rsp_kind(rsp_kind), .rsp_id(rsp_id), .cmd_acc(cmd_acc), .state_o(state_o)
    );

    function automatic logic [7:0] next_rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[7:0];
    endfunction

    task automatic check(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected behaviour from the requirements, state codes as in R1.
    function automatic void model(input int st, input logic [7:0] id, b0, b1, r,
                                  output int nst, output logic [7:0] nid,
                                  output bit v, output int k, output bit a,
                                  output string rq);
        nst = st; nid = id; v = 0; k = 0; a = 0; rq = "R12";
        if (b0 == 8'h08 || b0 == 8'h09 || b0 == 8'h0B) rq = "R9";
        if (st == 5) rq = "R11";
        if ((st == 1 || st == 2) && b0 == 8'h06 && b1 == 8'h00) begin
            nst = 2; nid = r; v = 1; k = 1; a = 1; rq = "R4";
        end else if (st == 2) begin
            if (b0 == 8'h06 && b1 == 8'h04) begin
                nid = {id[7:4], r[3:0]}; a = 1; v = (r[3:0] == 0); k = v ? 1 : 0; rq = "R5";
            end else if (b0[3:0] == 4'h6 && b0[7:4] != 0) begin
                a = 1; v = (id[3:0] == b0[7:4]); k = v ? 1 : 0; rq = "R6";
            end else if (b0 == 8'h0E) begin
                rq = "R7";
                if (b1 == id) begin nst = 3; a = 1; v = 1; k = 1; end
            end
        end else if (st == 3) begin
            case (b0)
                8'h08: begin a = 1; v = 1; k = 2; end
                8'h09: a = 1;
                8'h0B: begin a = 1; v = 1; k = 3; end
                8'h0C: begin nst = 2; a = 1; rq = "R10"; end
                8'h0F: begin nst = 5; a = 1; rq = "R11"; end
                8'h0E: begin
                    a = 1;
                    if (b1 == id) begin v = 1; k = 1; rq = "R7"; end
                    else begin nst = 4; rq = "R8"; end
                end
                default: ;
            endcase
        end else if (st == 4 && b0 == 8'h0E) begin
            rq = "R7";
            if (b1 == id) begin nst = 3; a = 1; v = 1; k = 1; end
        end
    endfunction

    // Present one frame, compare one cycle later, then confirm the pulses end (R13).
    task automatic frame(logic [7:0] b0, logic [7:0] b1, logic [7:0] r);
        int nst, k; logic [7:0] nid; bit v, a; string rq;
        model(exp_st, exp_id, b0, b1, r, nst, nid, v, k, a, rq);
        @(negedge clk);
        frame_vld = 1'b1; cmd_b0 = b0; cmd_b1 = b1; rnd = r;
        @(negedge clk);
        frame_vld = 1'b0;
        check(rq, "state", int'(state_o), nst);
        check(rq, "id", int'(rsp_id), int'(nid));
        check(rq, "rsp_vld", int'(rsp_vld), int'(v));
        check(rq, "kind", int'(rsp_kind), k);
        check(rq, "acc", int'(cmd_acc), int'(a));
        exp_st = nst; exp_id = nid;
        @(negedge clk);
        check("R13", "rsp_vld end", int'(rsp_vld), 0);
        check("R13", "acc end", int'(cmd_acc), 0);
    endtask

    // Field off then on: Power-off (R2), then Ready with a fresh ID (R3).
    task automatic power_cycle();
        logic [7:0] r;
        @(negedge clk);
        field_on = 1'b0;
        @(negedge clk);
        check("R2", "state off", int'(state_o), 0);
        r = next_rnd();
        field_on = 1'b1; rnd = r;
        @(negedge clk);
        check("R3", "state ready", int'(state_o), 1);
        check("R3", "id load", int'(rsp_id), int'(r));
        exp_st = 1; exp_id = r;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset state", int'(state_o), 0);
        check("R1", "reset id", int'(rsp_id), 0);
        check("R1", "reset rsp", int'(rsp_vld), 0);
        check("R1", "reset acc", int'(cmd_acc), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "off held", int'(state_o), 0);

        // Sweep of every first byte in every powered state.
        for (int t = 1; t <= 5; t++) begin
            for (int c = 0; c < 256; c++) begin
                for (int j = 0; j < 4; j++) begin
                    logic [7:0] b1;
                    power_cycle();
                    if (t >= 2) frame(8'h06, 8'h00, next_rnd());
                    if (t >= 3) frame(8'h0E, exp_id, next_rnd());
                    if (t == 4) frame(8'h0E, exp_id ^ 8'h5A, next_rnd());
                    if (t == 5) frame(8'h0F, 8'h00, next_rnd());
                    b1 = (j == 0) ? 8'h00 : (j == 1) ? 8'h04 : (j == 2) ? exp_id : (exp_id ^ 8'h01);
                    frame(8'(c), b1, next_rnd());
                end
            end
        end

        // Every Pcall16 nibble, then every slot number (R5, R6).
        for (int n = 0; n < 16; n++) begin
            power_cycle();
            frame(8'h06, 8'h00, next_rnd());
            frame(8'h06, 8'h04, {4'hA, 4'(n)});
            for (int s = 1; s < 16; s++) frame({4'(s), 4'h6}, 8'h00, next_rnd());
        end

        // Field loss with a frame presented in Selected (R2).
        power_cycle();
        frame(8'h06, 8'h00, next_rnd());
        frame(8'h0E, exp_id, next_rnd());
        @(negedge clk);
        field_on = 1'b0; frame_vld = 1'b1; cmd_b0 = 8'h08; cmd_b1 = 8'h00;
        @(negedge clk);
        frame_vld = 1'b0;
        check("R2", "state off", int'(state_o), 0);
        check("R2", "no reply", int'(rsp_vld), 0);
        check("R2", "no acc", int'(cmd_acc), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule